// File: doc/BRIEF.md
# Pipeline Exception and Flush Controller

This block decides when an exception or a return-from-exception takes effect in an in-order, six-stage processor pipeline. The stages are address, fetch, decode, execute, memory and write-back. Every cycle it looks at the valid bits and PCs of the early stages, the execute-stage stall, and the pending requests: an execute-stage fault, a data-TLB miss seen at execute, an instruction-TLB miss seen at fetch, an external interrupt, and a return instruction in execute.

A request takes effect only on a clock edge where the execute stage is free to advance. On an exception entry the block records the return PC and the cause. It clears the interrupt enable after saving its old value, points fetch at the handler vector, and kills every stage from execute back to address. The instructions in memory and write-back still complete. An instruction-TLB miss is not carried down the pipeline. It is taken at once as though the instruction in execute had faulted. The return PC is therefore the oldest instruction that has not yet executed, and that instruction fetches the faulting address again after the handler. A return sends fetch back to the saved PC, restores the interrupt enable, and kills only the stages behind execute.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `redirect` is 0, `kill` is 0, `epc` is 0, `cause` is 0 and `int_en` is 0.
- R2: Requests take effect only on an edge where `stall_x` is 0. A fault, a data-TLB miss and a return also need `vld_x`=1. Results appear on the registered outputs one cycle after that edge.
- R3: Cause IDs are fault=1, data-TLB miss=2, instruction-TLB miss=3 and interrupt=4. When several requests are pending, fault wins, then data-TLB miss, then instruction-TLB miss, then interrupt. Any exception outranks a return.
- R4: On entry, `new_pc` is `vec_base` + 32 × cause ID.
- R5: On entry, `epc` is loaded with `pc_x` when `vld_x`=1. Otherwise it is loaded with `pc_d` when `vld_d`=1, and with `pc_f` when neither is valid.
- R6: `kill` bit 0 is address, 1 is fetch, 2 is decode, 3 is execute, 4 is memory and 5 is write-back. An entry drives 6'h0F and a return drives 6'h07. Bits 4 and 5 are never set.
- R7: On a return, `new_pc` equals `epc` and `int_en` takes the value saved at the last entry. `epc` and `cause` are unchanged.
- R8: On entry, `int_en` is cleared and its previous value is saved for the next return.
- R9: An interrupt is ignored while `int_en` is 0.
- R10: A write of `ie_wdata_x` to the interrupt enable takes effect only when the execute instruction advances and neither an exception nor a return is taken. A write from a killed or stalled instruction leaves `int_en` unchanged.
- R11: `redirect` and `kill` are high for exactly one cycle per entry or return. All requests are ignored on the edge that ends a cycle in which `redirect` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_base | input | 32 | Base address of the handler vectors |
| pc_f | input | 32 | PC of the instruction in fetch |
| pc_d | input | 32 | PC of the instruction in decode |
| pc_x | input | 32 | PC of the instruction in execute |
| vld_f | input | 1 | Fetch stage holds a valid instruction |
| vld_d | input | 1 | Decode stage holds a valid instruction |
| vld_x | input | 1 | Execute stage holds a valid instruction |
| stall_x | input | 1 | Execute stage cannot advance this cycle |
| fault_x | input | 1 | Execute-stage fault request |
| dtlb_miss_x | input | 1 | Data-TLB miss of the execute instruction |
| itlb_miss_f | input | 1 | Instruction-TLB miss seen at fetch |
| irq | input | 1 | External interrupt request |
| eret_x | input | 1 | Return instruction in execute |
| ie_wr_x | input | 1 | Execute instruction writes the interrupt enable |
| ie_wdata_x | input | 1 | Value written to the interrupt enable |
| redirect | output | 1 | One-cycle strobe: fetch restarts at new_pc |
| new_pc | output | 32 | Fetch target for the redirect |
| kill | output | 6 | Per-stage kill bits, bit 0 address to bit 5 write-back |
| epc | output | 32 | Saved return address |
| cause | output | 3 | Cause ID of the last exception taken |
| int_en | output | 1 | Interrupt enable |

## Verification
The priority logic is driven with single requests and with stacked combinations of fault, data-TLB miss, instruction-TLB miss, interrupt and return. This separates the ranking order from the vector arithmetic and the cause encoding. The same requests are repeated with execute stalled, with execute empty and with interrupts masked, to tell the commit conditions apart. Bubble patterns with only decode or only fetch valid show which PC is saved. Return sequences that follow entries taken with interrupts enabled and with interrupts disabled check that the enable is saved and restored. A request held across several cycles checks the one-cycle strobe and the blocked edge that follows it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSTAGE = 6;
  localparam int ST_X   = 3;
  localparam int ST_M   = 4;
  localparam int ST_W   = 5;

  typedef enum logic [2:0] {
    CID_NONE  = 3'd0,
    CID_FAULT = 3'd1,
    CID_DTLB  = 3'd2,
    CID_ITLB  = 3'd3,
    CID_IRQ   = 3'd4
  } cause_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int XW = 32
) (
  input  logic           blocked,
  input  logic           stall_x,
  input  logic           vld_f,
  input  logic           vld_d,
  input  logic           vld_x,
  input  logic [XW-1:0]  pc_f,
  input  logic [XW-1:0]  pc_d,
  input  logic [XW-1:0]  pc_x,
  input  logic           fault_x,
  input  logic           dtlb_miss_x,
  input  logic           itlb_miss_f,
  input  logic           irq,
  input  logic           ie,
  input  logic           eret_x,
  input  logic           ie_wr_x,
  output logic           take_exc,
  output logic           take_ret,
  output logic           wr_ie,
  output exc_pkg::cause_e cid,
  output logic [XW-1:0]  save_pc
);
  import exc_pkg::*;

  logic any_go, x_go;

  // any request needs a free execute stage and a quiet cycle
  assign any_go = !stall_x && !blocked;
  assign x_go   = any_go && vld_x;

  always_comb begin
    cid = CID_NONE;
    if (x_go && fault_x)               cid = CID_FAULT;
    else if (x_go && dtlb_miss_x)      cid = CID_DTLB;
    else if (any_go && itlb_miss_f)    cid = CID_ITLB;
    else if (any_go && irq && ie)      cid = CID_IRQ;
  end

  assign take_exc = (cid != CID_NONE);
  assign take_ret = x_go && eret_x && !take_exc;
  assign wr_ie    = x_go && ie_wr_x && !take_exc && !take_ret;

  // oldest instruction that has not yet executed
  always_comb begin
    if (vld_x)      save_pc = pc_x;
    else if (vld_d) save_pc = pc_d;
    else            save_pc = pc_f;
    if (!vld_f && !vld_d && !vld_x) save_pc = pc_f;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int XW          = 32,
  parameter int STRIDE_LOG2 = 5
) (
  input  logic [XW-1:0]   base,
  input  exc_pkg::cause_e cid,
  output logic [XW-1:0]   vec
);
  localparam int IDW = $bits(exc_pkg::cause_e);

  logic [IDW-1:0] id_bits;
  assign id_bits = cid;
  assign vec = base + (XW'(id_bits) << STRIDE_LOG2);
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int XW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_exc,
  input  logic            take_ret,
  input  logic            wr_ie,
  input  logic            ie_wdata,
  input  exc_pkg::cause_e cid,
  input  logic [XW-1:0]   save_pc,
  output logic            ie,
  output logic [XW-1:0]   epc,
  output exc_pkg::cause_e cause
);
  import exc_pkg::*;

  logic ie_saved;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie       <= 1'b0;
      ie_saved <= 1'b0;
      epc      <= '0;
      cause    <= CID_NONE;
    end else if (take_exc) begin
      epc      <= save_pc;
      cause    <= cid;
      ie_saved <= ie;
      ie       <= 1'b0;
    end else if (take_ret) begin
      ie       <= ie_saved;
    end else if (wr_ie) begin
      ie       <= ie_wdata;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int XW          = 32,
  parameter int STRIDE_LOG2 = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [XW-1:0]             vec_base,
  input  logic [XW-1:0]             pc_f,
  input  logic [XW-1:0]             pc_d,
  input  logic [XW-1:0]             pc_x,
  input  logic                      vld_f,
  input  logic                      vld_d,
  input  logic                      vld_x,
  input  logic                      stall_x,
  input  logic                      fault_x,
  input  logic                      dtlb_miss_x,
  input  logic                      itlb_miss_f,
  input  logic                      irq,
  input  logic                      eret_x,
  input  logic                      ie_wr_x,
  input  logic                      ie_wdata_x,
  output logic                      redirect,
  output logic [XW-1:0]             new_pc,
  output logic [exc_pkg::NSTAGE-1:0] kill,
  output logic [XW-1:0]             epc,
  output logic [$bits(exc_pkg::cause_e)-1:0] cause,
  output logic                      int_en
);
  import exc_pkg::*;

  logic            take_exc, take_ret, wr_ie;
  cause_e          cid, cause_q;
  logic [XW-1:0]   save_pc, vec;
  logic [NSTAGE-1:0] kill_entry, kill_ret;

  exc_arbiter #(.XW(XW)) u_arb (
    .blocked     (redirect),
    .stall_x     (stall_x),
    .vld_f       (vld_f),
    .vld_d       (vld_d),
    .vld_x       (vld_x),
    .pc_f        (pc_f),
    .pc_d        (pc_d),
    .pc_x        (pc_x),
    .fault_x     (fault_x),
    .dtlb_miss_x (dtlb_miss_x),
    .itlb_miss_f (itlb_miss_f),
    .irq         (irq),
    .ie          (int_en),
    .eret_x      (eret_x),
    .ie_wr_x     (ie_wr_x),
    .take_exc    (take_exc),
    .take_ret    (take_ret),
    .wr_ie       (wr_ie),
    .cid         (cid),
    .save_pc     (save_pc)
  );

  exc_vector #(.XW(XW), .STRIDE_LOG2(STRIDE_LOG2)) u_vec (
    .base (vec_base),
    .cid  (cid),
    .vec  (vec)
  );

  exc_state #(.XW(XW)) u_state (
    .clk      (clk),
    .rst      (rst),
    .take_exc (take_exc),
    .take_ret (take_ret),
    .wr_ie    (wr_ie),
    .ie_wdata (ie_wdata_x),
    .cid      (cid),
    .save_pc  (save_pc),
    .ie       (int_en),
    .epc      (epc),
    .cause    (cause_q)
  );

  assign cause = cause_q;

  // entry kills execute and younger; return kills only younger
  for (genvar i = 0; i < NSTAGE; i++) begin : g_kill
    assign kill_entry[i] = (i <= ST_X);
    assign kill_ret[i]   = (i <  ST_X);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect <= 1'b0;
      new_pc   <= '0;
      kill     <= '0;
    end else if (take_exc) begin
      redirect <= 1'b1;
      new_pc   <= vec;
      kill     <= kill_entry;
    end else if (take_ret) begin
      redirect <= 1'b1;
      new_pc   <= epc;
      kill     <= kill_ret;
    end else begin
      redirect <= 1'b0;
      kill     <= '0;
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        stall_x,
  input logic        irq,
  input logic        fault_x,
  input logic        dtlb_miss_x,
  input logic        itlb_miss_f,
  input logic        eret_x,
  input logic        redirect,
  input logic [31:0] new_pc,
  input logic [5:0]  kill,
  input logic [31:0] epc,
  input logic        int_en
);
  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);

  // R11
  kill_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |-> (kill == 6'd0));

  // R6
  late_stages_live_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (!kill[exc_pkg::ST_M] && !kill[exc_pkg::ST_W]));

  // R2
  stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_x && !redirect) |=> !redirect);

  // R8
  entry_masks_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect && kill[exc_pkg::ST_X]) |-> !int_en);

  // R9
  masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !int_en && !fault_x && !dtlb_miss_x && !itlb_miss_f && !eret_x)
      |=> !redirect);

  // R7
  return_target_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect && !kill[exc_pkg::ST_X]) |-> (new_pc == epc));
endmodule

bind exc_ctrl exc_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall_x     (stall_x),
  .irq         (irq),
  .fault_x     (fault_x),
  .dtlb_miss_x (dtlb_miss_x),
  .itlb_miss_f (itlb_miss_f),
  .eret_x      (eret_x),
  .redirect    (redirect),
  .new_pc      (new_pc),
  .kill        (kill),
  .epc         (epc),
  .int_en      (int_en)
);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  localparam logic [31:0] PCX  = 32'h1000;
  localparam logic [31:0] PCD  = 32'h1004;
  localparam logic [31:0] PCF  = 32'h1008;
  localparam logic [31:0] BASE = 32'h8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] vec_base = BASE;
  logic [31:0] pc_f = PCF, pc_d = PCD, pc_x = PCX;
  logic vld_f = 0, vld_d = 0, vld_x = 0, stall_x = 0;
  logic fault_x = 0, dtlb_miss_x = 0, itlb_miss_f = 0, irq = 0, eret_x = 0;
  logic ie_wr_x = 0, ie_wdata_x = 0;
  logic redirect, int_en;
  logic [31:0] new_pc, epc;
  logic [5:0] kill;
  logic [2:0] cause;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  exc_ctrl dut (
    .clk(clk), .rst(rst), .vec_base(vec_base),
    .pc_f(pc_f), .pc_d(pc_d), .pc_x(pc_x),
    .vld_f(vld_f), .vld_d(vld_d), .vld_x(vld_x), .stall_x(stall_x),
    .fault_x(fault_x), .dtlb_miss_x(dtlb_miss_x), .itlb_miss_f(itlb_miss_f),
    .irq(irq), .eret_x(eret_x), .ie_wr_x(ie_wr_x), .ie_wdata_x(ie_wdata_x),
    .redirect(redirect), .new_pc(new_pc), .kill(kill), .epc(epc),
    .cause(cause), .int_en(int_en)
  );

  typedef struct packed {
    logic fault, dtlb, itlb, irq, eret, stall, vf, vd, vx, iew, iewd;
    logic        rd;
    logic [2:0]  cid;
    logic [5:0]  kl;
    logic [31:0] npc;
    logic [31:0] ep;
    logic        ie;
  } vec_t;

  localparam int NV = 23;
  //             flt dtl itl irq ert stl vf vd vx iew iwd  rd cid   kill    npc        epc  ie
  localparam vec_t TBL [NV] = '{
    '{1,0,0,0,0,0,0,0,1,0,0, 1,3'd1,6'h0F,32'h8020,PCX,0}, // R4 R5 fault
    '{1,0,0,0,0,1,0,0,1,0,0, 0,3'd1,6'h00,32'h0,   PCX,0}, // R2 stalled
    '{1,0,0,0,0,0,0,0,0,0,0, 0,3'd1,6'h00,32'h0,   PCX,0}, // R2 empty execute
    '{0,1,0,0,0,0,0,0,0,0,0, 0,3'd1,6'h00,32'h0,   PCX,0}, // R2 dtlb bubble
    '{0,0,0,0,0,0,0,0,1,1,1, 0,3'd1,6'h00,32'h0,   PCX,1}, // R10 enable write
    '{0,0,0,1,0,0,0,1,0,0,0, 1,3'd4,6'h0F,32'h8080,PCD,0}, // R5 R8 irq, decode pc
    '{0,0,0,0,1,0,0,0,1,0,0, 1,3'd4,6'h07,PCD,     PCD,1}, // R7 return
    '{1,1,1,1,0,0,0,0,1,0,0, 1,3'd1,6'h0F,32'h8020,PCX,0}, // R3 all pending
    '{0,1,1,1,0,0,0,0,1,0,0, 1,3'd2,6'h0F,32'h8040,PCX,0}, // R3 dtlb over itlb
    '{0,0,0,1,0,0,0,0,1,0,0, 0,3'd2,6'h00,32'h0,   PCX,0}, // R9 masked irq
    '{0,0,1,0,0,0,1,0,0,0,0, 1,3'd3,6'h0F,32'h8060,PCF,0}, // R5 itlb, fetch pc
    '{0,0,1,1,0,0,1,1,1,0,0, 1,3'd3,6'h0F,32'h8060,PCX,0}, // R5 itlb, execute pc
    '{0,0,0,0,1,0,0,0,1,0,0, 1,3'd3,6'h07,PCX,     PCX,0}, // R7 restore 0
    '{0,0,0,0,0,1,0,0,1,1,1, 0,3'd3,6'h00,32'h0,   PCX,0}, // R10 stalled write
    '{0,0,0,0,0,0,0,0,1,1,1, 0,3'd3,6'h00,32'h0,   PCX,1}, // R10 write lands
    '{1,0,0,0,0,0,0,0,1,1,0, 1,3'd1,6'h0F,32'h8020,PCX,0}, // R10 killed write
    '{0,0,0,0,1,0,0,0,1,0,0, 1,3'd1,6'h07,PCX,     PCX,1}, // R7 R10 saved 1
    '{0,1,0,0,1,0,0,0,1,0,0, 1,3'd2,6'h0F,32'h8040,PCX,0}, // R3 dtlb over return
    '{0,0,0,0,1,1,0,0,1,0,0, 0,3'd2,6'h00,32'h0,   PCX,0}, // R2 stalled return
    '{0,0,0,0,1,0,0,0,1,0,0, 1,3'd2,6'h07,PCX,     PCX,1}, // R7 return
    '{0,0,0,1,0,0,0,0,1,0,0, 1,3'd4,6'h0F,32'h8080,PCX,0}, // R3 irq enabled
    '{0,0,0,0,1,0,0,0,1,0,0, 1,3'd4,6'h07,PCX,     PCX,1}, // R7 return
    '{0,0,0,1,0,1,0,0,1,0,0, 0,3'd4,6'h00,32'h0,   PCX,1}  // R2 stalled irq
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {fault_x, dtlb_miss_x, itlb_miss_f, irq, eret_x, stall_x} = '0;
    {vld_f, vld_d, vld_x, ie_wr_x, ie_wdata_x} = '0;
  endtask

  initial begin : watchdog
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1", "redirect", {31'd0, redirect}, 32'd0);
    chk("R1", "kill", {26'd0, kill}, 32'd0);
    chk("R1", "epc", epc, 32'd0);
    chk("R1", "cause", {29'd0, cause}, 32'd0);
    chk("R1", "int_en", {31'd0, int_en}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fault_x = TBL[i].fault; dtlb_miss_x = TBL[i].dtlb; itlb_miss_f = TBL[i].itlb;
      irq = TBL[i].irq; eret_x = TBL[i].eret; stall_x = TBL[i].stall;
      vld_f = TBL[i].vf; vld_d = TBL[i].vd; vld_x = TBL[i].vx;
      ie_wr_x = TBL[i].iew; ie_wdata_x = TBL[i].iewd;
      @(posedge clk); #1;
      chk("R2", $sformatf("row %0d redirect", i), {31'd0, redirect}, {31'd0, TBL[i].rd});
      chk("R6", $sformatf("row %0d kill", i), {26'd0, kill}, {26'd0, TBL[i].kl});
      chk("R5", $sformatf("row %0d epc", i), epc, TBL[i].ep);
      chk("R3", $sformatf("row %0d cause", i), {29'd0, cause}, {29'd0, TBL[i].cid});
      chk("R8", $sformatf("row %0d int_en", i), {31'd0, int_en}, {31'd0, TBL[i].ie});
      if (TBL[i].rd) chk("R4", $sformatf("row %0d new_pc", i), new_pc, TBL[i].npc);
      @(negedge clk); idle_inputs();
      @(posedge clk); #1;
      chk("R11", $sformatf("row %0d strobe drop", i), {31'd0, redirect}, 32'd0);
    end

    // R11: a held request is blocked on the edge after the strobe
    @(negedge clk); fault_x = 1; vld_x = 1;
    @(posedge clk); #1;
    chk("R11", "held first", {31'd0, redirect}, 32'd1);
    @(posedge clk); #1;
    chk("R11", "held blocked", {31'd0, redirect}, 32'd0);
    chk("R11", "held blocked kill", {26'd0, kill}, 32'd0);
    @(posedge clk); #1;
    chk("R11", "held again", {31'd0, redirect}, 32'd1);
    @(negedge clk); idle_inputs();
    @(posedge clk);

    // R11: an enable write in the strobe cycle is dropped
    @(negedge clk); vld_x = 1; ie_wr_x = 1; ie_wdata_x = 1; fault_x = 1;
    @(posedge clk); #1;
    @(negedge clk); fault_x = 0;
    @(posedge clk); #1;
    chk("R11", "write in strobe cycle", {31'd0, int_en}, 32'd0);
    @(negedge clk); idle_inputs();
    @(posedge clk);

    // R4: vector follows a new base
    @(negedge clk); vec_base = 32'h0004_0000; itlb_miss_f = 1; vld_f = 1;
    @(posedge clk); #1;
    chk("R4", "new base itlb vector", new_pc, 32'h0004_0060);
    chk("R5", "new base epc", epc, PCF);
    @(negedge clk); idle_inputs();

    // R1: mid-run reset clears enable and saved pc
    @(negedge clk); vld_x = 1; ie_wr_x = 1; ie_wdata_x = 1;
    @(negedge clk); idle_inputs(); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1", "reset int_en", {31'd0, int_en}, 32'd0);
    chk("R1", "reset epc", epc, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule